// File: doc/BRIEF.md
# USB Host Channel Transfer Chunker

This block sits between a host controller's transfer request logic and one hardware host channel. It takes a single endpoint transfer of any length up to 2^LEN_W-1 bytes and breaks it into chunks that the channel can run in one go. For every chunk it presents the byte count, the packet count, the starting data toggle and the split-transaction flags on a one-cycle launch strobe. It then waits for the channel's halt report and decides whether to issue another chunk, finish, or give up with a retry or error status.

When a full- or low-speed device hangs behind a high-speed root port, each chunk becomes a split transaction. An acknowledged start-split is followed by complete-splits, which are re-issued while the hub answers "not yet" and the frame window since the start-split is still open. Interrupt endpoints get an odd-frame flag chosen from the current frame number. A watchdog on the halt wait turns a silent channel into a timeout status.

Top module: `usb_chunker`

## Requirements
- R1: The largest chunk is min(MAX_PKTS × max_pkt, MAX_XFER, BUF_BYTES), rounded down to a whole multiple of max_pkt. A chunk issued at this cap carries cap / max_pkt packets.
- R2: Each chunk is min(bytes still to move, largest chunk). Its packet count is ceil(chunk / max_pkt), never below 1. A zero-length transfer issues one chunk of length 0 with 1 packet.
- R3: Split mode applies when dev_hs=0 and port_hs=1. In split mode every chunk is at most max_pkt bytes and 1 packet, with launch_split=1. With port_hs=0 there is no split and no one-packet limit.
- R4: In split mode, a halt with halt_ack=1 while no complete-split is pending arms the complete-split phase and records frame_num. The next chunk has launch_csplit=1 and the transfer continues.
- R5: While a complete-split is pending, halt_nyet=1 keeps it pending. The status becomes retry (1) once (frame_num − recorded frame) mod 2^FN_W exceeds CSPLIT_WINDOW. Any halt without halt_nyet ends the complete-split phase.
- R6: launch_odd=1 exactly when ep_type=2'b11 (interrupt; 00 control, 01 isochronous, 10 bulk) and frame_num[0]=0 at launch.
- R7: A chunk's byte count is chunk − halt_remain for IN (dir_in=1) and the full chunk for OUT. A completed chunk that moves fewer bytes than requested ends the transfer with status 0.
- R8: Another chunk follows only if the result is success and either (bytes moved < length and no short chunk) or a complete-split is pending. status: 0 ok, 1 retry, 2 error, 3 timeout. halt_cmpl gives success, halt_nak or halt_frovr gives retry, anything else gives error. A failed chunk adds no bytes to actual_len.
- R9: The first chunk carries pid_init. Every later chunk carries the halt_pid of the previous halt, and end_pid holds the last toggle reported.
- R10: If no halt arrives within HALT_TIMEOUT cycles of waiting, the transfer ends with status 3 and actual_len equal to the bytes already moved. The toggle stays as it was.
- R11: After reset, busy, launch and done are 0, and status and actual_len are 0.
- R12: launch and done are single-cycle pulses. busy stays high from the accepted start until done, and is low in the cycle done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| xfer_len | input | LEN_W | Total transfer length in bytes |
| max_pkt | input | MPS_W | Endpoint max packet size |
| ep_type | input | 2 | 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| dir_in | input | 1 | 1 for IN, 0 for OUT |
| dev_hs | input | 1 | Device runs at high speed |
| port_hs | input | 1 | Root port runs at high speed |
| pid_init | input | 2 | Starting data toggle |
| frame_num | input | FN_W | Current (micro)frame number |
| halt_valid | input | 1 | Channel halted; halt_* fields valid |
| halt_cmpl | input | 1 | Chunk completed |
| halt_nak | input | 1 | NAK received |
| halt_frovr | input | 1 | Frame overrun |
| halt_nyet | input | 1 | NYET received |
| halt_ack | input | 1 | ACK received |
| halt_remain | input | LEN_W | Bytes not transferred at halt |
| halt_pid | input | 2 | Data toggle reported at halt |
| launch | output | 1 | Chunk launch strobe |
| launch_len | output | LEN_W | Chunk byte count |
| launch_pkts | output | PKT_W | Chunk packet count |
| launch_pid | output | 2 | Chunk starting toggle |
| launch_split | output | 1 | Chunk is a split transaction |
| launch_csplit | output | 1 | Chunk is a complete-split |
| launch_odd | output | 1 | Schedule in an odd frame |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished strobe |
| actual_len | output | LEN_W | Bytes moved by the finished transfer |
| status | output | 2 | Final status of the transfer |
| end_pid | output | 2 | Toggle to keep for the endpoint |

## Verification
A wrong byte counter or remainder shows on the very next launch as a wrong launch_len or launch_pkts. If the counter is wrong on the last chunk, it shows one cycle after that halt as a wrong actual_len or as a missing or extra chunk. A stale complete-split flag or recorded frame shows as a wrong launch_csplit on the following chunk, or as a retry status that comes too early or too late. The frame-number wrap case checks the latter. A wrong toggle register shows on the next launch_pid or on end_pid, and a broken wait counter shifts the timeout done pulse away from its exact cycle.

// File: rtl/usb_chunk_pkg.sv
package usb_chunk_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_RETRY   = 2'd1,
    ST_ERROR   = 2'd2,
    ST_TIMEOUT = 2'd3
  } xfer_status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LAUNCH,
    S_WAIT
  } chunk_state_e;

  localparam logic [1:0] EP_INTR = 2'b11;

  // Largest chunk: three caps, then trimmed to whole packets.
  function automatic logic [31:0] chunk_cap(input logic [31:0] mps,
                                            input logic [31:0] max_pkts,
                                            input logic [31:0] max_xfer,
                                            input logic [31:0] buf_bytes);
    logic [31:0] m;
    logic [31:0] c;
    m = (mps == 32'd0) ? 32'd1 : mps;
    c = max_pkts * m;
    if (c > max_xfer) c = max_xfer;
    if (c > buf_bytes) c = buf_bytes;
    return (c / m) * m;
  endfunction

  // Packets needed for a length, at least one.
  function automatic logic [31:0] pkt_count(input logic [31:0] len,
                                            input logic [31:0] mps);
    logic [31:0] m;
    m = (mps == 32'd0) ? 32'd1 : mps;
    if (len <= m) return 32'd1;
    return (len + m - 32'd1) / m;
  endfunction

endpackage

// File: rtl/chunk_sizer.sv
module chunk_sizer
  import usb_chunk_pkg::*;
#(
  parameter int LEN_W     = 20,
  parameter int MPS_W     = 11,
  parameter int PKT_W     = 10,
  parameter int MAX_PKTS  = 256,
  parameter int MAX_XFER  = 65536,
  parameter int BUF_BYTES = 65536
) (
  input  logic [LEN_W-1:0] remain,
  input  logic [MPS_W-1:0] mps,
  input  logic             split,
  output logic [LEN_W-1:0] len,
  output logic [PKT_W-1:0] pkts,
  output logic [LEN_W-1:0] cap
);

  logic [31:0] m32, cap32, len32, pkt32;

  always_comb begin
    m32   = 32'(mps);
    cap32 = split ? m32 : chunk_cap(m32, 32'(MAX_PKTS), 32'(MAX_XFER), 32'(BUF_BYTES));
    if (32'(remain) > cap32) begin
      len32 = cap32;
      pkt32 = pkt_count(cap32, m32);
    end else begin
      len32 = 32'(remain);
      pkt32 = pkt_count(len32, m32);
    end
    len  = LEN_W'(len32);
    pkts = PKT_W'(pkt32);
    cap  = LEN_W'(cap32);
  end

endmodule

// File: rtl/split_tracker.sv
module split_tracker #(
  parameter int FN_W          = 14,
  parameter int CSPLIT_WINDOW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            eval,
  input  logic            split_en,
  input  logic            nyet,
  input  logic            ack,
  input  logic [FN_W-1:0] frame,
  output logic            cs_phase,
  output logic            nyet_hold,
  output logic            nyet_late,
  output logic            ack_arm
);

  logic [FN_W-1:0] ss_frame_q;
  logic [FN_W-1:0] gap;

  assign gap       = frame - ss_frame_q;
  assign nyet_hold = eval && cs_phase && nyet;
  assign nyet_late = nyet_hold && (32'(gap) > 32'(CSPLIT_WINDOW));
  assign ack_arm   = eval && !cs_phase && split_en && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_phase   <= 1'b0;
      ss_frame_q <= '0;
    end else if (clear) begin
      cs_phase   <= 1'b0;
    end else if (eval) begin
      cs_phase <= cs_phase ? nyet : ack_arm;
      if (ack_arm) ss_frame_q <= frame;
    end
  end

endmodule

// File: rtl/halt_timer.sv
module halt_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic halt,
  output logic expired
);

  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired = run && !halt && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (!run)                       cnt_q <= '0;
    else if (cnt_q != CNT_W'(LIMIT - 1)) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/usb_chunker.sv
module usb_chunker
  import usb_chunk_pkg::*;
#(
  parameter int LEN_W         = 20,
  parameter int MPS_W         = 11,
  parameter int PKT_W         = 10,
  parameter int FN_W          = 14,
  parameter int MAX_PKTS      = 256,
  parameter int MAX_XFER      = 65536,
  parameter int BUF_BYTES     = 65536,
  parameter int CSPLIT_WINDOW = 4,
  parameter int HALT_TIMEOUT  = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic [1:0]       ep_type,
  input  logic             dir_in,
  input  logic             dev_hs,
  input  logic             port_hs,
  input  logic [1:0]       pid_init,
  input  logic [FN_W-1:0]  frame_num,
  input  logic             halt_valid,
  input  logic             halt_cmpl,
  input  logic             halt_nak,
  input  logic             halt_frovr,
  input  logic             halt_nyet,
  input  logic             halt_ack,
  input  logic [LEN_W-1:0] halt_remain,
  input  logic [1:0]       halt_pid,
  output logic             launch,
  output logic [LEN_W-1:0] launch_len,
  output logic [PKT_W-1:0] launch_pkts,
  output logic [1:0]       launch_pid,
  output logic             launch_split,
  output logic             launch_csplit,
  output logic             launch_odd,
  output logic             busy,
  output logic             done,
  output logic [LEN_W-1:0] actual_len,
  output logic [1:0]       status,
  output logic [1:0]       end_pid
);

  chunk_state_e     state_q;
  xfer_status_e     status_q;
  logic [LEN_W-1:0] total_q, moved_q, cur_len_q, actual_q;
  logic [MPS_W-1:0] mps_q;
  logic [1:0]       type_q, pid_q;
  logic             in_q, split_q, done_q;

  // Named events for the checker and the sequencer
  logic             accept, eval, expired, ep_is_intr;
  logic             cs_phase, nyet_hold, nyet_late, ack_arm;
  logic [LEN_W-1:0] remain, sz_len, sz_cap;
  logic [PKT_W-1:0] sz_pkts;

  assign accept     = (state_q == S_IDLE) && start;
  assign eval       = (state_q == S_WAIT) && halt_valid;
  assign remain     = total_q - moved_q;
  assign ep_is_intr = (type_q == EP_INTR);

  chunk_sizer #(
    .LEN_W(LEN_W), .MPS_W(MPS_W), .PKT_W(PKT_W),
    .MAX_PKTS(MAX_PKTS), .MAX_XFER(MAX_XFER), .BUF_BYTES(BUF_BYTES)
  ) i_sizer (
    .remain(remain), .mps(mps_q), .split(split_q),
    .len(sz_len), .pkts(sz_pkts), .cap(sz_cap)
  );

  split_tracker #(.FN_W(FN_W), .CSPLIT_WINDOW(CSPLIT_WINDOW)) i_split (
    .clk(clk), .rst_n(rst_n), .clear(accept), .eval(eval),
    .split_en(split_q), .nyet(halt_nyet), .ack(halt_ack), .frame(frame_num),
    .cs_phase(cs_phase), .nyet_hold(nyet_hold), .nyet_late(nyet_late),
    .ack_arm(ack_arm)
  );

  halt_timer #(.LIMIT(HALT_TIMEOUT)) i_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == S_WAIT), .halt(halt_valid),
    .expired(expired)
  );

  // Halt evaluation
  xfer_status_e     base_st, res_st;
  logic [LEN_W-1:0] chunk_bytes, moved_next;
  logic             cs_next, short_chunk, go_on;

  always_comb begin
    if (halt_cmpl)                  base_st = ST_OK;
    else if (halt_nak || halt_frovr) base_st = ST_RETRY;
    else                            base_st = ST_ERROR;
    if (base_st != ST_OK)           chunk_bytes = '0;
    else if (in_q)                  chunk_bytes = cur_len_q - halt_remain;
    else                            chunk_bytes = cur_len_q;
    if (nyet_hold)                  res_st = nyet_late ? ST_RETRY : ST_OK;
    else if (ack_arm)               res_st = ST_OK;
    else                            res_st = base_st;
    cs_next     = cs_phase ? halt_nyet : ack_arm;
    moved_next  = moved_q + chunk_bytes;
    short_chunk = chunk_bytes < cur_len_q;
    go_on       = (res_st == ST_OK) &&
                  (((moved_next < total_q) && !short_chunk) || cs_next);
  end

  assign launch        = (state_q == S_LAUNCH);
  assign launch_len    = sz_len;
  assign launch_pkts   = sz_pkts;
  assign launch_pid    = pid_q;
  assign launch_split  = launch && split_q;
  assign launch_csplit = launch && cs_phase;
  assign launch_odd    = launch && ep_is_intr && !frame_num[0];
  assign busy          = (state_q != S_IDLE);
  assign done          = done_q;
  assign actual_len    = actual_q;
  assign status        = status_q;
  assign end_pid       = pid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      status_q  <= ST_OK;
      total_q   <= '0;
      moved_q   <= '0;
      cur_len_q <= '0;
      actual_q  <= '0;
      mps_q     <= '0;
      type_q    <= '0;
      pid_q     <= '0;
      in_q      <= 1'b0;
      split_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start) begin
          total_q  <= xfer_len;
          moved_q  <= '0;
          mps_q    <= max_pkt;
          type_q   <= ep_type;
          in_q     <= dir_in;
          split_q  <= !dev_hs && port_hs;
          pid_q    <= pid_init;
          status_q <= ST_OK;
          actual_q <= '0;
          state_q  <= S_LAUNCH;
        end
        S_LAUNCH: begin
          cur_len_q <= sz_len;
          state_q   <= S_WAIT;
        end
        S_WAIT: if (eval) begin
          pid_q <= halt_pid;
          if (go_on) begin
            moved_q <= moved_next;
            state_q <= S_LAUNCH;
          end else begin
            status_q <= res_st;
            actual_q <= (res_st == ST_OK) ? moved_next : moved_q;
            done_q   <= 1'b1;
            state_q  <= S_IDLE;
          end
        end else if (expired) begin
          status_q <= ST_TIMEOUT;
          actual_q <= moved_q;
          done_q   <= 1'b1;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/usb_chunker_chk.sv
module usb_chunker_chk #(
  parameter int LEN_W = 20,
  parameter int PKT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             launch,
  input logic [LEN_W-1:0] launch_len,
  input logic [PKT_W-1:0] launch_pkts,
  input logic             launch_split,
  input logic             launch_csplit,
  input logic             launch_odd,
  input logic [LEN_W-1:0] cap_len,
  input logic             ep_is_intr,
  input logic             busy,
  input logic             done
);

  assert_len_within_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> launch_len <= cap_len);

  assert_pkts_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> launch_pkts != '0);

  assert_split_one_pkt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && launch_split) |-> launch_pkts == PKT_W'(1));

  assert_csplit_in_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch_csplit |-> launch_split);

  assert_odd_intr_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch_odd |-> ep_is_intr);

  assert_launch_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind usb_chunker usb_chunker_chk #(.LEN_W(LEN_W), .PKT_W(PKT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .launch_len(launch_len),
  .launch_pkts(launch_pkts), .launch_split(launch_split),
  .launch_csplit(launch_csplit), .launch_odd(launch_odd), .cap_len(sz_cap),
  .ep_is_intr(ep_is_intr), .busy(busy), .done(done)
);

// File: tb/test_usb_chunker.sv
module test_usb_chunker;

  localparam int TB_PKTS = 4;
  localparam int TB_XFER = 1000;
  localparam int TB_BUF  = 65536;
  localparam int TB_TMO  = 50;
  localparam int NV      = 8;

  // Table: length, max packet, direction, short chunk index (-1 none), bytes left on it
  localparam int V_LEN [NV] = '{600, 2000, 1500, 700, 64, 65, 0, 300};
  localparam int V_MPS [NV] = '{64, 300, 512, 64, 64, 64, 64, 64};
  localparam int V_IN  [NV] = '{1, 1, 0, 1, 1, 1, 1, 0};
  localparam int V_SC  [NV] = '{-1, -1, -1, 1, -1, -1, -1, 0};
  localparam int V_SR  [NV] = '{0, 0, 0, 10, 0, 0, 0, 20};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] xfer_len = '0;
  logic [10:0] max_pkt = '0;
  logic [1:0]  ep_type = 2'b10;
  logic        dir_in = 1'b1, dev_hs = 1'b1, port_hs = 1'b1;
  logic [1:0]  pid_init = '0;
  logic [13:0] frame_num = 14'd4;
  logic        halt_valid = 1'b0, halt_cmpl = 1'b0, halt_nak = 1'b0;
  logic        halt_frovr = 1'b0, halt_nyet = 1'b0, halt_ack = 1'b0;
  logic [19:0] halt_remain = '0;
  logic [1:0]  halt_pid = '0;
  logic        launch, launch_split, launch_csplit, launch_odd, busy, done;
  logic [19:0] launch_len, actual_len;
  logic [9:0]  launch_pkts;
  logic [1:0]  launch_pid, status, end_pid;

  usb_chunker #(.MAX_PKTS(TB_PKTS), .MAX_XFER(TB_XFER), .BUF_BYTES(TB_BUF),
                .HALT_TIMEOUT(TB_TMO)) i_usb_chunker (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
    .max_pkt(max_pkt), .ep_type(ep_type), .dir_in(dir_in), .dev_hs(dev_hs),
    .port_hs(port_hs), .pid_init(pid_init), .frame_num(frame_num),
    .halt_valid(halt_valid), .halt_cmpl(halt_cmpl), .halt_nak(halt_nak),
    .halt_frovr(halt_frovr), .halt_nyet(halt_nyet), .halt_ack(halt_ack),
    .halt_remain(halt_remain), .halt_pid(halt_pid), .launch(launch),
    .launch_len(launch_len), .launch_pkts(launch_pkts), .launch_pid(launch_pid),
    .launch_split(launch_split), .launch_csplit(launch_csplit),
    .launch_odd(launch_odd), .busy(busy), .done(done),
    .actual_len(actual_len), .status(status), .end_pid(end_pid)
  );

  always #5 clk = ~clk;

  int  checks = 0;
  int  fails  = 0;
  bit  reported = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Returns 1 on a launch, 0 on done (or on no event, which is counted)
  task automatic wait_evt(output bit got_launch);
    int n = 0;
    while (!launch && !done && n < 500) begin
      @(negedge clk);
      n++;
    end
    if (!launch && !done) begin
      checks++;
      fails++;
      $display("FAIL R12 no launch or done actual=0 expected=1");
    end
    got_launch = launch;
  endtask

  task automatic kick(input int len, input int mps, input bit in_dir, input logic [1:0] typ,
                      input bit dhs, input bit phs, input logic [1:0] pid0);
    @(negedge clk);
    xfer_len = 20'(len); max_pkt = 11'(mps); dir_in = in_dir; ep_type = typ;
    dev_hs = dhs; port_hs = phs; pid_init = pid0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic halt(input bit c, input bit nk, input bit fo, input bit ny, input bit ak,
                      input int rem, input logic [1:0] pid, input int frame);
    @(posedge clk);
    @(negedge clk);
    halt_valid = 1'b1; halt_cmpl = c; halt_nak = nk; halt_frovr = fo;
    halt_nyet = ny; halt_ack = ak; halt_remain = 20'(rem); halt_pid = pid;
    frame_num = 14'(frame);
    @(posedge clk);
    @(negedge clk);
    halt_valid = 1'b0; halt_cmpl = 1'b0; halt_nak = 1'b0; halt_frovr = 1'b0;
    halt_nyet = 1'b0; halt_ack = 1'b0; halt_remain = '0;
  endtask

  function automatic int tb_cap(input int mps);
    int best = 0;
    int lim = (TB_XFER < TB_BUF) ? TB_XFER : TB_BUF;
    for (int k = 1; k <= TB_PKTS; k++)
      if (k * mps <= lim) best = k * mps;
    return best;
  endfunction

  task automatic run_vector(input int v);
    int  cap = tb_cap(V_MPS[v]);
    int  moved = 0;
    int  idx = 0;
    bit  more = 1'b1;
    bit  g;
    kick(V_LEN[v], V_MPS[v], V_IN[v] != 0, 2'b10, 1'b1, 1'b1, 2'd2);
    while (more) begin
      int rem = V_LEN[v] - moved;
      int clen = (rem > cap) ? cap : rem;
      int pk = (clen == 0) ? 1 : (clen + V_MPS[v] - 1) / V_MPS[v];
      int left = (idx == V_SC[v]) ? V_SR[v] : 0;
      int act = (V_IN[v] != 0) ? clen - left : clen;
      wait_evt(g);
      chk("R8", "launch expected", int'(g), 1);
      if (!g) break;
      chk((rem > cap) ? "R1" : "R2", "launch_len", int'(launch_len), clen);
      chk((rem > cap) ? "R1" : "R2", "launch_pkts", int'(launch_pkts), pk);
      chk("R9", "launch_pid", int'(launch_pid), (idx == 0) ? 2 : (idx & 3));
      chk("R6", "launch_odd bulk", int'(launch_odd), 0);
      chk("R3", "launch_split", int'(launch_split), 0);
      halt(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, left, 2'((idx + 1) & 3), 4);
      moved += act;
      idx++;
      more = (act == clen) && (moved < V_LEN[v]);
    end
    wait_evt(g);
    chk("R8", "done expected", int'(g), 0);
    chk("R8", "status", int'(status), 0);
    chk("R7", "actual_len", int'(actual_len), moved);
    chk("R9", "end_pid", int'(end_pid), idx & 3);
    @(negedge clk);
    chk("R12", "done pulse", int'(done), 0);
    chk("R12", "busy after done", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    bit g;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "busy", int'(busy), 0);
    chk("R11", "launch", int'(launch), 0);
    chk("R11", "done", int'(done), 0);
    chk("R11", "status", int'(status), 0);
    chk("R11", "actual_len", int'(actual_len), 0);

    for (int v = 0; v < NV; v++) run_vector(v);

    // R8: NAK on the second chunk -> retry, first chunk's bytes only
    kick(600, 64, 1'b1, 2'b10, 1'b1, 1'b1, 2'd0);
    wait_evt(g);
    chk("R12", "busy during transfer", int'(busy), 1);
    halt(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 2'd1, 4);
    wait_evt(g);
    chk("R9", "pid after halt", int'(launch_pid), 1);
    halt(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 2'd0, 4);
    wait_evt(g);
    chk("R8", "nak status", int'(status), 1);
    chk("R8", "nak actual", int'(actual_len), 256);
    chk("R9", "end_pid after nak", int'(end_pid), 0);

    // R8: bare halt -> error; frame overrun -> retry
    kick(100, 64, 1'b1, 2'b10, 1'b1, 1'b1, 2'd0);
    wait_evt(g);
    halt(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 2'd0, 4);
    wait_evt(g);
    chk("R8", "error status", int'(status), 2);
    chk("R8", "error actual", int'(actual_len), 0);
    kick(100, 64, 1'b1, 2'b10, 1'b1, 1'b1, 2'd0);
    wait_evt(g);
    halt(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 2'd0, 4);
    wait_evt(g);
    chk("R8", "overrun status", int'(status), 1);

    // R10: silent channel
    kick(100, 64, 1'b1, 2'b10, 1'b1, 1'b1, 2'd3);
    wait_evt(g);
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R10", "cycles to done", n, TB_TMO + 1);
    chk("R10", "timeout status", int'(status), 3);
    chk("R10", "timeout actual", int'(actual_len), 0);
    chk("R10", "timeout toggle kept", int'(end_pid), 3);

    // R3..R5: split sequence
    kick(20, 8, 1'b1, 2'b10, 1'b0, 1'b1, 2'd0);
    wait_evt(g);
    chk("R3", "split len", int'(launch_len), 8);
    chk("R3", "split pkts", int'(launch_pkts), 1);
    chk("R3", "split flag", int'(launch_split), 1);
    chk("R4", "first csplit", int'(launch_csplit), 0);
    halt(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 2'd0, 100);
    wait_evt(g);
    chk("R4", "csplit after ack", int'(launch_csplit), 1);
    halt(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 2'd0, 102);
    wait_evt(g);
    chk("R5", "csplit kept on nyet", int'(launch_csplit), 1);
    halt(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 2'd1, 103);
    wait_evt(g);
    chk("R5", "csplit ended", int'(launch_csplit), 0);
    chk("R5", "next start-split len", int'(launch_len), 8);
    halt(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 2'd1, 16382);
    wait_evt(g);
    chk("R4", "csplit after second ack", int'(launch_csplit), 1);
    halt(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 2'd1, 2);
    wait_evt(g);
    chk("R5", "wrap gap 4 continues", int'(g), 1);
    chk("R5", "csplit after wrap", int'(launch_csplit), 1);
    halt(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 2'd1, 3);
    wait_evt(g);
    chk("R5", "late nyet ends", int'(g), 0);
    chk("R5", "late nyet status", int'(status), 1);
    chk("R5", "late nyet actual", int'(actual_len), 8);

    // R3: low-speed device on a full-speed port -> no split
    kick(20, 8, 1'b1, 2'b10, 1'b0, 1'b0, 2'd0);
    wait_evt(g);
    chk("R3", "no split flag", int'(launch_split), 0);
    chk("R3", "no split len", int'(launch_len), 20);
    chk("R3", "no split pkts", int'(launch_pkts), 3);
    halt(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 2'd0, 4);
    wait_evt(g);
    chk("R7", "no split actual", int'(actual_len), 20);

    // R6: interrupt endpoint odd-frame flag
    frame_num = 14'd4;
    kick(8, 8, 1'b1, 2'b11, 1'b1, 1'b1, 2'd0);
    wait_evt(g);
    chk("R6", "odd on even frame", int'(launch_odd), 1);
    halt(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 2'd0, 4);
    wait_evt(g);
    frame_num = 14'd7;
    kick(8, 8, 1'b1, 2'b11, 1'b1, 1'b1, 2'd0);
    wait_evt(g);
    chk("R6", "no odd on odd frame", int'(launch_odd), 0);
    halt(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 2'd0, 7);
    wait_evt(g);
    chk("R8", "intr status", int'(status), 0);

    summary();
  end

endmodule